// File: doc/BRIEF.md
# DMA-Driven LIN Receive Frame Controller

This block is the master side of a LIN link for frames whose response comes from a slave. Once armed, it runs frames on its own. For each frame it raises a transmit DMA request and takes one header word from memory. It then sends the header on the bus: a break, a delimiter, the sync character and the protected identifier. After that it collects the slave's response bytes and hands each data byte to memory through a separate receive DMA request/acknowledge pair. It checks the trailing checksum byte and flags a mismatch.

Two status outputs show whether a header is being sent or a response is being received. Software reads them before it asks for low-power stop. Stop is acknowledged only while the sequencer is idle and no received byte is still waiting for the DMA. While the stop request is held, no new frame is started.

Top module: `lin_rx_dma_ctrl`

## Requirements
- R1: No transmit DMA request is raised unless LIN mode, transmitter enable, receiver enable and the receive-DMA enable are all high.
- R2: The transmit DMA request stays high until acknowledged, and one 16-bit header word is consumed per frame. The word has these fields: bits 5:0 hold the identifier, bits 9:6 hold the data length, and bit 10 selects the enhanced checksum. Any length above LEN_MAX (8) is treated as 8.
- R3: The header starts with BRK_BITS (13) bit times of low level, followed by exactly one bit time of high delimiter. The line is high whenever no header is being sent.
- R4: The sync byte 0x55 and then the protected identifier follow back to back. Each is sent as a 10-bit character: start bit 0, eight data bits LSB first, stop bit 1.
- R5: The protected identifier is {P1, P0, id[5:0]}, with P0 = id0^id1^id2^id4 and P1 = ~(id1^id3^id4^id5).
- R6: After the identifier, exactly length data bytes and one checksum byte are received. Each data byte raises a receive DMA request carrying the byte, held stable until acknowledged.
- R7: The expected checksum is the bitwise inverse of the 8-bit sum with end-around carry over the data bytes. In enhanced mode the sum also includes the protected identifier. The checksum-error output is set at frame end on a mismatch and cleared when the next header word is accepted.
- R8: Transmit-active is high exactly while the header is being sent. Receive-active is high while the response is being collected. The two are never high together.
- R9: The stop acknowledge is high only while stop is requested, the sequencer is idle and no receive DMA request is pending. While stop is held, no new header fetch starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lin_mode_i | input | 1 | LIN mode selected |
| tx_en_i | input | 1 | Transmitter enable |
| rx_en_i | input | 1 | Receiver enable |
| rxdma_en_i | input | 1 | Arms autonomous DMA frame operation |
| txdma_req_o | output | 1 | Request for the next header word |
| txdma_ack_i | input | 1 | Header word is valid on txdma_data_i |
| txdma_data_i | input | 16 | Header word |
| rxdma_req_o | output | 1 | Received data byte is ready |
| rxdma_ack_i | input | 1 | Received byte has been taken |
| rxdma_data_o | output | 8 | Received data byte |
| txd_o | output | 1 | Serial line output, idle high |
| rxd_i | input | 1 | Serial line input |
| tx_active_o | output | 1 | Header transmission in progress |
| rx_active_o | output | 1 | Response reception in progress |
| cksum_err_o | output | 1 | Checksum mismatch on the last frame |
| stop_req_i | input | 1 | Low-power stop request |
| stop_ack_o | output | 1 | Stop acknowledged |

## Verification
A wrong sequencer state shows up on txd_o within one bit time: a break that is too short, a delimiter that is too long, or a missing character. It also shows up as status outputs that disagree with the line. A wrong length counter or checksum accumulator becomes visible at the end of that same frame, as a missing or extra receive DMA request or a wrong checksum-error flag. A stop gate that lets go too early raises the acknowledge during a header, at the latest by the first sync bit.

// File: rtl/lin_rx_pkg.sv
package lin_rx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_BREAK, S_SYNC, S_PID, S_RESP
  } seq_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'h55;

  function automatic logic [7:0] calc_pid(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  function automatic logic [7:0] add_carry(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[7:0] + {7'b0, t[8]};
  endfunction
endpackage

// File: rtl/lin_tx_ser.sv
module lin_tx_ser #(
  parameter int CPB  = 16,
  parameter int SH_W = 14,
  localparam int CNT_W = $clog2(CPB),
  localparam int NB_W  = $clog2(SH_W + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [SH_W-1:0] pat_i,
  input  logic [NB_W-1:0] nbits_i,
  output logic            txd_o,
  output logic            last_o
);
  localparam logic [CNT_W-1:0] TICK_LAST = CNT_W'(CPB - 1);

  logic [SH_W-1:0]  sh_q;
  logic [NB_W-1:0]  left_q;
  logic [CNT_W-1:0] tick_q;
  logic             busy;

  assign busy   = (left_q != '0);
  assign last_o = busy && (tick_q == TICK_LAST) && (left_q == NB_W'(1));
  assign txd_o  = busy ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      tick_q <= '0;
    end else if (load_i) begin
      sh_q   <= pat_i;
      left_q <= nbits_i;
      tick_q <= '0;
    end else if (busy) begin
      if (tick_q == TICK_LAST) begin
        tick_q <= '0;
        sh_q   <= {1'b1, sh_q[SH_W-1:1]};
        left_q <= left_q - NB_W'(1);
      end else begin
        tick_q <= tick_q + CNT_W'(1);
      end
    end
  end

  AST_LOAD_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (!busy || last_o));  // R4
endmodule

// File: rtl/lin_rx_deser.sv
module lin_rx_deser #(
  parameter int CPB = 16,
  localparam int CNT_W = $clog2(CPB)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       rxd_i,
  output logic       valid_o,
  output logic [7:0] byte_o
);
  localparam logic [CNT_W-1:0] TICK_LAST = CNT_W'(CPB - 1);
  localparam logic [CNT_W-1:0] TICK_HALF = CNT_W'(CPB / 2 - 1);

  typedef enum logic [1:0] {D_IDLE, D_START, D_DATA, D_STOP} dstate_e;

  dstate_e          st_q;
  logic             s1_q, s2_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;

  assign byte_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= D_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (!en_i) begin
        st_q <= D_IDLE;
      end else begin
        unique case (st_q)
          D_IDLE: if (!s2_q) begin
            st_q  <= D_START;
            cnt_q <= '0;
          end
          D_START: if (cnt_q == TICK_HALF) begin
            cnt_q <= '0;
            bit_q <= '0;
            st_q  <= s2_q ? D_IDLE : D_DATA;
          end else cnt_q <= cnt_q + CNT_W'(1);
          D_DATA: if (cnt_q == TICK_LAST) begin
            cnt_q <= '0;
            sh_q  <= {s2_q, sh_q[7:1]};
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) st_q <= D_STOP;
          end else cnt_q <= cnt_q + CNT_W'(1);
          D_STOP: if (cnt_q == TICK_LAST) begin
            cnt_q   <= '0;
            st_q    <= D_IDLE;
            valid_o <= s2_q;
          end else cnt_q <= cnt_q + CNT_W'(1);
          default: st_q <= D_IDLE;
        endcase
      end
    end
  end

  AST_VALID_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(en_i));  // R6
endmodule

// File: rtl/lin_rx_dma_ctrl.sv
module lin_rx_dma_ctrl
  import lin_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int BRK_BITS     = 13,
  parameter int LEN_MAX      = 8,
  parameter int WORD_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lin_mode_i,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              rxdma_en_i,
  output logic              txdma_req_o,
  input  logic              txdma_ack_i,
  input  logic [WORD_W-1:0] txdma_data_i,
  output logic              rxdma_req_o,
  input  logic              rxdma_ack_i,
  output logic [7:0]        rxdma_data_o,
  output logic              txd_o,
  input  logic              rxd_i,
  output logic              tx_active_o,
  output logic              rx_active_o,
  output logic              cksum_err_o,
  input  logic              stop_req_i,
  output logic              stop_ack_o
);
  localparam int SH_W  = BRK_BITS + 1;
  localparam int NB_W  = $clog2(SH_W + 1);
  localparam int LEN_W = 4;
  localparam int REM_W = $clog2(LEN_MAX + 2);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(LEN_MAX);

  seq_state_e       state_q;
  logic [7:0]       pid_q, sum_q, rxdata_q;
  logic [LEN_W-1:0] len_q;
  logic [REM_W-1:0] remain_q;
  logic             enh_q, err_q, rxreq_q;
  logic             enable;

  logic             ser_load, ser_last;
  logic [SH_W-1:0]  ser_pat;
  logic [NB_W-1:0]  ser_nb;
  logic             rx_valid;
  logic [7:0]       rx_byte;
  logic [LEN_W-1:0] len_in;

  assign enable       = lin_mode_i & tx_en_i & rx_en_i & rxdma_en_i;
  assign len_in       = txdma_data_i[9:6];
  assign txdma_req_o  = (state_q == S_FETCH);
  assign tx_active_o  = (state_q == S_BREAK) || (state_q == S_SYNC) || (state_q == S_PID);
  assign rx_active_o  = (state_q == S_RESP);
  assign rxdma_req_o  = rxreq_q;
  assign rxdma_data_o = rxdata_q;
  assign cksum_err_o  = err_q;
  assign stop_ack_o   = stop_req_i && (state_q == S_IDLE) && !rxreq_q;

  // next character is loaded in the last cycle of the current one: no idle gap
  always_comb begin
    ser_load = 1'b0;
    ser_pat  = '1;
    ser_nb   = '0;
    unique case (state_q)
      S_FETCH: if (txdma_ack_i) begin
        ser_load = 1'b1;
        ser_pat  = {1'b1, {BRK_BITS{1'b0}}};
        ser_nb   = NB_W'(SH_W);
      end
      S_BREAK: if (ser_last) begin
        ser_load     = 1'b1;
        ser_pat[9:0] = {1'b1, SYNC_BYTE, 1'b0};
        ser_nb       = NB_W'(10);
      end
      S_SYNC: if (ser_last) begin
        ser_load     = 1'b1;
        ser_pat[9:0] = {1'b1, pid_q, 1'b0};
        ser_nb       = NB_W'(10);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      pid_q    <= '0;
      len_q    <= '0;
      enh_q    <= 1'b0;
      remain_q <= '0;
      sum_q    <= '0;
      err_q    <= 1'b0;
      rxreq_q  <= 1'b0;
      rxdata_q <= '0;
    end else begin
      if (rxreq_q && rxdma_ack_i) rxreq_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (enable && !stop_req_i) state_q <= S_FETCH;
        S_FETCH: if (txdma_ack_i) begin
          pid_q   <= calc_pid(txdma_data_i[5:0]);
          len_q   <= (len_in > LEN_CAP) ? LEN_CAP : len_in;
          enh_q   <= txdma_data_i[10];
          err_q   <= 1'b0;
          state_q <= S_BREAK;
        end
        S_BREAK: if (ser_last) state_q <= S_SYNC;
        S_SYNC:  if (ser_last) state_q <= S_PID;
        S_PID: if (ser_last) begin
          remain_q <= REM_W'(len_q) + REM_W'(1);
          sum_q    <= enh_q ? pid_q : 8'h00;
          state_q  <= S_RESP;
        end
        S_RESP: if (rx_valid) begin
          if (remain_q == REM_W'(1)) begin
            err_q   <= (rx_byte != ~sum_q);
            state_q <= S_IDLE;
          end else begin
            rxdata_q <= rx_byte;
            rxreq_q  <= 1'b1;
            sum_q    <= add_carry(sum_q, rx_byte);
            remain_q <= remain_q - REM_W'(1);
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  lin_tx_ser #(.CPB(CLKS_PER_BIT), .SH_W(SH_W)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ser_load),
    .pat_i  (ser_pat),
    .nbits_i(ser_nb),
    .txd_o  (txd_o),
    .last_o (ser_last)
  );

  lin_rx_deser #(.CPB(CLKS_PER_BIT)) u_deser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rx_active_o),
    .rxd_i  (rxd_i),
    .valid_o(rx_valid),
    .byte_o (rx_byte)
  );

  AST_TXREQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txdma_req_o && !txdma_ack_i |=> txdma_req_o);  // R2
  AST_FETCH_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txdma_req_o) |-> $past(enable && !stop_req_i));  // R1
  AST_RXREQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxdma_req_o && !rxdma_ack_i |=> rxdma_req_o && $stable(rxdma_data_o));  // R6
  AST_TXD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_active_o |-> txd_o);  // R3
  AST_ACTIVE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_active_o && rx_active_o));  // R8
  AST_STOP_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_ack_o |-> !tx_active_o && !rx_active_o && !txdma_req_o && !rxdma_req_o);  // R9
endmodule

// File: tb/lin_rx_dma_ctrl_test.sv
module lin_rx_dma_ctrl_test;
  localparam int CPB = 8;
  localparam int BRK = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lin_mode = 0, tx_en = 0, rx_en = 0, rxdma_en = 0;
  logic txdma_req, txdma_ack = 0;
  logic [15:0] txdma_data = '0;
  logic rxdma_req, rxdma_ack = 0;
  logic [7:0] rxdma_data;
  logic txd, rxd = 1'b1;
  logic tx_active, rx_active, cksum_err, stop_req = 0, stop_ack;

  int nvec = 0, nerr = 0;
  int rx_cnt = 0;
  logic [7:0] rx_got [16];
  logic acker_on = 1'b1;

  always #2.5 clk = ~clk;

  lin_rx_dma_ctrl #(.CLKS_PER_BIT(CPB), .BRK_BITS(BRK)) uut (
    .clk_i(clk), .rst_ni(rst_n), .lin_mode_i(lin_mode), .tx_en_i(tx_en),
    .rx_en_i(rx_en), .rxdma_en_i(rxdma_en), .txdma_req_o(txdma_req),
    .txdma_ack_i(txdma_ack), .txdma_data_i(txdma_data), .rxdma_req_o(rxdma_req),
    .rxdma_ack_i(rxdma_ack), .rxdma_data_o(rxdma_data), .txd_o(txd), .rxd_i(rxd),
    .tx_active_o(tx_active), .rx_active_o(rx_active), .cksum_err_o(cksum_err),
    .stop_req_i(stop_req), .stop_ack_o(stop_ack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pid_of(input int id);
    logic [5:0] i;
    i = 6'(id);
    return {~(i[1] ^ i[3] ^ i[4] ^ i[5]), i[0] ^ i[1] ^ i[2] ^ i[4], i};
  endfunction

  function automatic logic [7:0] csum(input logic [7:0] s, input logic [7:0] b);
    int t;
    t = int'(s) + int'(b);
    if (t > 255) t = t - 255;
    return 8'(t);
  endfunction

  // receive DMA sink
  initial forever begin
    @(negedge clk);
    if (acker_on && rxdma_req && !rxdma_ack) begin
      rx_got[rx_cnt[3:0]] = rxdma_data;
      rx_cnt++;
      rxdma_ack = 1'b1;
    end else rxdma_ack = 1'b0;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic decode_char(output logic [7:0] b, output bit stop_ok);
    while (txd !== 1'b0) @(negedge clk);
    wait_n(CPB / 2);
    for (int k = 0; k < 8; k++) begin
      wait_n(CPB);
      b[k] = txd;
    end
    wait_n(CPB);
    stop_ok = (txd === 1'b1);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [9:0] f;
    f = {1'b1, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      rxd = f[k];
      wait_n(CPB);
    end
    rxd = 1'b1;
    wait_n(CPB);
  endtask

  task automatic do_frame(input int id, input int lenf, input bit enh,
                          input bit corrupt, input bit stop_mid);
    int lo, hi, elen;
    logic [7:0] b, s, ck, pid, exp_b;
    bit sok;
    pid  = pid_of(id);
    elen = (lenf > 8) ? 8 : lenf;
    while (txdma_req !== 1'b1) @(negedge clk);
    chk(!tx_active && !rx_active, "R8 idle before fetch", {tx_active, rx_active}, 0);
    txdma_data = {5'b0, enh, 4'(lenf), 6'(id)};
    txdma_ack  = 1'b1;
    rx_cnt     = 0;
    @(negedge clk);
    txdma_ack = 1'b0;
    chk(!txdma_req, "R2 request dropped after ack", txdma_req, 0);
    chk(cksum_err == 1'b0, "R7 error cleared on new header", cksum_err, 0);
    if (stop_mid) stop_req = 1'b1;
    lo = 0;
    while (txd === 1'b0) begin lo++; @(negedge clk); end
    chk(lo == BRK * CPB, "R3 break length", lo, BRK * CPB);
    hi = 0;
    while (txd === 1'b1) begin hi++; @(negedge clk); end
    chk(hi == CPB, "R3 delimiter length", hi, CPB);
    chk(tx_active && !rx_active, "R8 tx_active in header", {tx_active, rx_active}, 2);
    if (stop_mid) chk(!stop_ack, "R9 no stop ack during header", stop_ack, 0);
    decode_char(b, sok);
    chk(b == 8'h55 && sok, "R4 sync character", b, 8'h55);
    decode_char(b, sok);
    chk(b == pid && sok, "R5 protected identifier", b, pid);
    while (tx_active === 1'b1) @(negedge clk);
    chk(rx_active, "R8 rx_active in response", rx_active, 1);
    wait_n(2 * CPB);
    s = enh ? pid : 8'h00;
    for (int k = 0; k < elen; k++) begin
      exp_b = 8'((id * 37 + k * 11 + 5) & 255);
      s = csum(s, exp_b);
      send_byte(exp_b);
    end
    if (stop_mid) chk(!stop_ack, "R9 no stop ack during response", stop_ack, 0);
    ck = ~s;
    if (corrupt) ck = ck ^ 8'h01;
    send_byte(ck);
    wait_n(4);
    chk(!rx_active, "R8 rx_active cleared at frame end", rx_active, 0);
    chk(rx_cnt == elen, "R6 receive DMA count", rx_cnt, elen);
    for (int k = 0; k < elen && k < 16; k++) begin
      exp_b = 8'((id * 37 + k * 11 + 5) & 255);
      chk(rx_got[k] == exp_b, "R6 received byte", rx_got[k], exp_b);
    end
    chk(cksum_err == corrupt, "R7 checksum flag", cksum_err, corrupt);
    if (stop_mid) begin
      chk(stop_ack, "R9 stop ack when idle", stop_ack, 1);
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (txdma_req) begin
          chk(0, "R9 fetch started under stop", 1, 0);
          break;
        end
      end
      stop_req = 1'b0;
      wait_n(2);
      chk(txdma_req, "R9 fetch resumes after stop release", txdma_req, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    chk(txd && !txdma_req && !rxdma_req && !tx_active && !rx_active && !cksum_err,
        "R3 reset state", {txd, txdma_req, rxdma_req, tx_active, rx_active, cksum_err}, 6'h20);
    // R1: each single enable missing blocks the fetch
    for (int m = 0; m < 4; m++) begin
      bit seen;
      {lin_mode, tx_en, rx_en, rxdma_en} = 4'hF & ~(4'h1 << m);
      seen = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (txdma_req) seen = 1;
      end
      chk(!seen, "R1 fetch blocked with an enable low", seen, 0);
    end
    chk(stop_ack == 1'b0, "R9 no ack without request", stop_ack, 0);
    {lin_mode, tx_en, rx_en, rxdma_en} = 4'hF;
    wait_n(2);
    chk(txdma_req, "R1 fetch raised when all enables high", txdma_req, 1);
    wait_n(5);
    chk(txdma_req, "R2 request held without ack", txdma_req, 1);
    for (int id = 0; id < 64; id++)
      do_frame(id, id % 11, id[1], (id % 5) == 2, id == 20);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule